// File: doc/BRIEF.md
# Self-Timed Program Sequencer with Ready/Busy Status

This block sits behind the serial front end of a three-wire serial memory. The front end recognises start bits and decodes complete command frames. It hands each decoded frame to this block as a one-cycle request carrying an operation code, a word address and a data word. The block keeps a write-enable latch. It holds a program request once the frame's final bit has arrived, and it starts a timed program cycle on the chip-select falling edge that follows.

When the cycle completes, the block updates an internal word array: one word, every word, or an erase to all ones. While status is being shown and chip select is high, the serial output line reports busy (0) during the cycle and ready (1) after it. It drops back to high impedance when the next start bit is recognised. The array read port serves the front end's read path combinationally. A low-supply lockout input vetoes any cycle that is about to start. Two outputs, `busy_o` and a one-cycle `done_o`, expose the cycle timing directly.

Top module: `prog_seq`

## Requirements
- R1: After reset every array word reads FFFFh, the write-enable latch is cleared, `busy_o` and `done_o` are 0 and `do_oe_o` is 0.
- R2: A request with code 1 sets the write-enable latch and code 2 clears it. While the latch is clear, program requests (codes 3 to 6) change no word and start no cycle.
- R3: An accepted program request starts a cycle only on the next chip-select falling edge; `busy_o` is 1 from the clock edge that samples `cs_i` low after high, and no cycle starts while `cs_i` stays high.
- R4: A frame that never delivers `cmd_valid_i` (abandoned before its final bit) starts nothing when chip select falls.
- R5: `busy_o` stays high for exactly PROG_CYCLES clock cycles; `done_o` is high for the single cycle after it falls, and the array update is visible in that same cycle.
- R6: Code 3 stores `cmd_data_i` at `cmd_addr_i`; code 4 sets the addressed word to FFFFh.
- R7: Code 5 stores `cmd_data_i` in every word within one cycle; code 6 sets every word to FFFFh within one cycle.
- R8: Status is armed when a cycle starts. While armed and `cs_i` is 1, `do_oe_o` is 1 and `do_o` is 0 during the cycle and 1 after it. `do_oe_o` is 0 whenever `cs_i` is 0, and a start bit seen while not busy disarms status.
- R9: Every request arriving while `busy_o` is 1 is ignored, including codes 1 and 2.
- R10: If `lockout_i` is 1 when chip select falls, no cycle starts and the pending request is discarded.
- R11: `rd_data_o` shows the word at `rd_addr_i` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip-select level, already synchronised |
| start_bit_i | input | 1 | One-cycle pulse: front end recognised a start bit |
| cmd_valid_i | input | 1 | One-cycle pulse: a frame's final bit was received |
| cmd_op_i | input | 3 | Decoded operation: 1 enable, 2 disable, 3 write, 4 erase, 5 write-all, 6 erase-all |
| cmd_addr_i | input | ADDR_W | Word address of the frame |
| cmd_data_i | input | DATA_W | Data word of the frame |
| lockout_i | input | 1 | Low-supply lockout; blocks a cycle from starting |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | DATA_W | Read port data |
| do_o | output | 1 | Status level for the serial output (0 busy, 1 ready) |
| do_oe_o | output | 1 | Serial output drive enable; 0 means high impedance |
| busy_o | output | 1 | Program cycle in progress |
| done_o | output | 1 | One-cycle pulse after a cycle ends |

## Verification
The assertions watch the cycle timing on every clock. They check that a cycle begins only after a sampled chip-select low with lockout clear, that busy lasts exactly PROG_CYCLES cycles, and that done is a lone pulse at the fall of busy. They also check that the output is driven only with chip select high and never reads ready while busy. Only the bench scenarios can show the effects on the array and the latch. These include words written, erased or filled together, and requests dropped because the latch was clear, the cycle was busy, the frame was abandoned or lockout was raised. They also show status being disarmed by a start bit.

// File: rtl/prog_seq_pkg.sv
// Shared operation codes for the program sequencer.
// Assumes the front end delivers the 3-bit code unchanged from its decoder.
package prog_seq_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_WEN   = 3'd1,
        OP_WDS   = 3'd2,
        OP_WRITE = 3'd3,
        OP_ERASE = 3'd4,
        OP_WRAL  = 3'd5,
        OP_ERAL  = 3'd6
    } prog_op_e;

    // True for operations that need a timed program cycle
    function automatic logic is_program(prog_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRAL) || (op == OP_ERAL);
    endfunction

    // True for operations that touch every word
    function automatic logic is_bulk(prog_op_e op);
        return (op == OP_WRAL) || (op == OP_ERAL);
    endfunction

    // True for operations that store ones instead of data
    function automatic logic is_erase(prog_op_e op);
        return (op == OP_ERASE) || (op == OP_ERAL);
    endfunction
endpackage

// File: rtl/prog_wel.sv
// Write-enable latch. Cleared by reset; set and cleared only by accepted requests.
// Assumes set and clear are never asserted together.
module prog_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    // Hold the enable state between requests
    always_ff @(posedge clk) begin
        if (!rst_n)     wel_o <= 1'b0;
        else if (clr_i) wel_o <= 1'b0;
        else if (set_i) wel_o <= 1'b1;
    end
endmodule

// File: rtl/prog_timer.sv
// Fixed-length cycle timer. A start pulse holds busy for CYCLES clocks,
// last_o marks the final busy clock and done_o pulses once afterwards.
// Assumes start_i is never raised while busy.
module prog_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o,
    output logic done_o
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign last_o = busy_o && (cnt == '0);

    // Count the cycle down and flag its completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_o;
            if (start_i) begin
                busy_o <= 1'b1;
                cnt    <= LOAD;
            end else if (last_o) begin
                busy_o <= 1'b0;
            end else if (busy_o) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/prog_array.sv
// Word array with reset to all ones, a combinational read port and a
// single commit port that updates one word or all words at once.
module prog_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              bulk_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ONES = '1;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] wval;

    assign wval      = erase_i ? ONES : data_i;
    assign rd_data_o = words[rd_addr_i];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        // Update word i on a matching or bulk commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= ONES;
            else if (commit_i && (bulk_i || (addr_i == ADDR_W'(i))))
                words[i] <= wval;
        end
    end
endmodule

// File: rtl/prog_status.sv
// Ready/busy status on the serial output. Armed when a cycle starts,
// disarmed by a start bit seen while idle; drives only with chip select high.
module prog_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic start_bit_i,
    input  logic launch_i,
    input  logic busy_i,
    output logic do_o,
    output logic do_oe_o
);
    logic armed;

    // Track whether status is on show
    always_ff @(posedge clk) begin
        if (!rst_n)                       armed <= 1'b0;
        else if (launch_i)                armed <= 1'b1;
        else if (start_bit_i && !busy_i)  armed <= 1'b0;
    end

    assign do_oe_o = armed && cs_i;
    assign do_o    = do_oe_o && !busy_i;
endmodule

// File: rtl/prog_seq.sv
// Program sequencer top. Accepts decoded requests from the serial front end,
// keeps the write-enable latch, holds a program request until chip select
// falls, runs the timed cycle, commits to the array and drives status.
// Assumes cs_i is synchronous to clk and start/valid pulses last one cycle.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              start_bit_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              lockout_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              do_o,
    output logic              do_oe_o,
    output logic              busy_o,
    output logic              done_o
);
    prog_op_e          op;
    prog_op_e          pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic              pend_valid;
    logic              cs_q;
    logic              cs_fall;
    logic              accept;
    logic              wel;
    logic              launch;
    logic              last;

    assign op      = prog_op_e'(cmd_op_i);
    assign cs_fall = cs_q && !cs_i;
    assign accept  = cmd_valid_i && !busy_o;
    assign launch  = cs_fall && pend_valid && !lockout_i && !busy_o;

    // Remember chip select for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_i;
    end

    prog_wel u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && (op == OP_WEN)),
        .clr_i (accept && (op == OP_WDS)),
        .wel_o (wel)
    );

    // Hold an accepted program request until chip select falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_op    <= OP_NOP;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (cs_fall || start_bit_i) begin
            pend_valid <= 1'b0;
        end else if (accept && wel && is_program(op)) begin
            pend_valid <= 1'b1;
            pend_op    <= op;
            pend_addr  <= cmd_addr_i;
            pend_data  <= cmd_data_i;
        end
    end

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .busy_o  (busy_o),
        .last_o  (last),
        .done_o  (done_o)
    );

    prog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (last),
        .bulk_i    (is_bulk(pend_op)),
        .erase_i   (is_erase(pend_op)),
        .addr_i    (pend_addr),
        .data_i    (pend_data),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    prog_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs_i),
        .start_bit_i (start_bit_i),
        .launch_i    (launch),
        .busy_i      (busy_o),
        .do_o        (do_o),
        .do_oe_o     (do_oe_o)
    );
endmodule

// File: rtl/prog_seq_chk.sv
// Timing checker for prog_seq, attached by bind. Observes ports only.
module prog_seq_chk #(
    parameter int PROG_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic cs_i,
    input logic lockout_i,
    input logic busy_o,
    input logic done_o,
    input logic do_o,
    input logic do_oe_o
);
    logic [31:0] run_cnt;

    // Count busy clocks of the current cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= '0;
        else if (busy_o) run_cnt <= run_cnt + 1;
        else             run_cnt <= '0;
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy_o && !done_o && !do_oe_o));

    // R3
    start_after_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(cs_i));

    // R10
    start_not_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(lockout_i));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt < PROG_CYCLES));

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(run_cnt) == PROG_CYCLES - 1));

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    drive_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe_o |-> cs_i);

    // R8
    busy_shows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe_o && busy_o) |-> !do_o);
endmodule

bind prog_seq prog_seq_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs_i),
    .lockout_i (lockout_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o)
);

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int PC = 40;

    localparam logic [2:0] C_WEN = 3'd1, C_WDS = 3'd2, C_WRITE = 3'd3,
                           C_ERASE = 3'd4, C_WRAL = 3'd5, C_ERAL = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0, start_bit_i = 1'b0, cmd_valid_i = 1'b0, lockout_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [AW-1:0] cmd_addr_i = '0, rd_addr_i = '0;
    logic [DW-1:0] cmd_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic do_o, do_oe_o, busy_o, done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct { logic [AW-1:0] addr; logic [DW-1:0] val; string tag; } exp_t;
    exp_t sb_q[$];
    int pending = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue an expected word
    task automatic expect_word(logic [AW-1:0] a, logic [DW-1:0] v, string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        pending++;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    // Monitor: read each expected word back through the read port (R11)
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            @(negedge clk);
            rd_addr_i = e.addr;
            #1;
            check({e.tag, " R11 read"}, 32'(rd_data_o), 32'(e.val));
            pending--;
        end
    end

    // Raise chip select, present a start bit, then a complete frame
    task automatic frame(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk); cs_i = 1'b1;
        @(negedge clk); start_bit_i = 1'b1;
        @(negedge clk); start_bit_i = 1'b0;
        cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d; cmd_valid_i = 1'b1;
        @(negedge clk); cmd_valid_i = 1'b0;
    endtask

    task automatic drop_cs();
        @(negedge clk); cs_i = 1'b0;
    endtask

    // Drop chip select and measure the busy length and done pulse
    task automatic run_cycle(string tag);
        int n = 0;
        drop_cs();
        for (int k = 0; k < PC + 5; k++) begin
            @(negedge clk);
            if (busy_o) n++;
            else break;
        end
        check({tag, " R5 busy length"}, 32'(n), 32'(PC));
        check({tag, " R5 done pulse"}, 32'(done_o), 32'd1);
    endtask

    task automatic expect_idle(string tag);
        repeat (3) @(negedge clk);
        check(tag, 32'(busy_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        check("R1 oe", 32'(do_oe_o), 32'd0);
        expect_word(8'd0, 16'hFFFF, "R1");
        expect_word(8'd255, 16'hFFFF, "R1");
        drain();

        // R2 latch clear after reset: write ignored
        frame(C_WRITE, 8'd5, 16'h1234);
        drop_cs();
        expect_idle("R2 no cycle while disabled");
        expect_word(8'd5, 16'hFFFF, "R2");
        drain();

        // R2 enable, R3 no start while CS high, R5 timing, R6 write
        frame(C_WEN, 8'd0, 16'h0);
        drop_cs();
        frame(C_WRITE, 8'd5, 16'h1234);
        expect_idle("R3 held while CS high");
        run_cycle("R3");
        expect_word(8'd5, 16'h1234, "R6 write");
        drain();

        // R8 status: busy low, ready high, disarm on start bit
        frame(C_WRITE, 8'd6, 16'hABCD);
        drop_cs();
        repeat (3) @(negedge clk);
        check("R8 oe low with CS low", 32'(do_oe_o), 32'd0);
        cs_i = 1'b1;
        @(negedge clk);
        check("R8 oe busy", 32'(do_oe_o), 32'd1);
        check("R8 busy level", 32'(do_o), 32'd0);
        wait (!busy_o);
        @(negedge clk);
        check("R8 ready level", 32'(do_o), 32'd1);
        check("R8 oe ready", 32'(do_oe_o), 32'd1);
        start_bit_i = 1'b1;
        @(negedge clk); start_bit_i = 1'b0;
        check("R8 disarm by start bit", 32'(do_oe_o), 32'd0);
        drop_cs();
        expect_word(8'd6, 16'hABCD, "R6 write2");
        drain();

        // R4 abandoned frame: no final bit
        @(negedge clk); cs_i = 1'b1;
        @(negedge clk); start_bit_i = 1'b1;
        @(negedge clk); start_bit_i = 1'b0;
        drop_cs();
        expect_idle("R4 abandoned frame");

        // R9 requests during busy are ignored
        frame(C_WRITE, 8'd7, 16'h0707);
        drop_cs();
        repeat (2) @(negedge clk);
        cs_i = 1'b1;
        @(negedge clk); cmd_op_i = C_WDS; cmd_valid_i = 1'b1;
        @(negedge clk); cmd_op_i = C_WRITE; cmd_addr_i = 8'd8; cmd_data_i = 16'h0808;
        @(negedge clk); cmd_valid_i = 1'b0; cs_i = 1'b0;
        wait (!busy_o);
        drop_cs();
        expect_idle("R9 busy write not started");
        expect_word(8'd7, 16'h0707, "R9 first");
        expect_word(8'd8, 16'hFFFF, "R9 ignored write");
        drain();
        frame(C_WRITE, 8'd9, 16'h0909);
        run_cycle("R9 latch kept");
        expect_word(8'd9, 16'h0909, "R9 latch kept");
        drain();

        // R6 erase
        frame(C_ERASE, 8'd5, 16'h0);
        run_cycle("R6 erase");
        expect_word(8'd5, 16'hFFFF, "R6 erase");
        drain();

        // R10 lockout blocks and discards
        frame(C_WRITE, 8'd10, 16'h1010);
        lockout_i = 1'b1;
        drop_cs();
        expect_idle("R10 locked");
        lockout_i = 1'b0;
        @(negedge clk); cs_i = 1'b1;
        drop_cs();
        expect_idle("R10 discarded");
        expect_word(8'd10, 16'hFFFF, "R10");
        drain();

        // R7 write-all and erase-all
        frame(C_WRAL, 8'd0, 16'h5A5A);
        run_cycle("R7 wral");
        expect_word(8'd0, 16'h5A5A, "R7 wral");
        expect_word(8'd128, 16'h5A5A, "R7 wral");
        expect_word(8'd255, 16'h5A5A, "R7 wral");
        drain();
        frame(C_ERAL, 8'd0, 16'h0);
        run_cycle("R7 eral");
        expect_word(8'd0, 16'hFFFF, "R7 eral");
        expect_word(8'd200, 16'hFFFF, "R7 eral");
        drain();

        // R2 disable then write ignored
        frame(C_WDS, 8'd0, 16'h0);
        drop_cs();
        frame(C_WRITE, 8'd3, 16'h3333);
        drop_cs();
        expect_idle("R2 disabled again");
        expect_word(8'd3, 16'hFFFF, "R2 disabled");
        drain();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule